// File: doc/BRIEF.md
# Burst Enable Delay Tracker

This block sits in a transmit path and produces a delayed copy of a burst data-enable. Time is counted in symbol strobes, not clock cycles. The strobe is a single-cycle pulse in the system clock domain. The input enable is sampled only in cycles where the strobe is high. The delayed enable rises a short, fixed number of strobes after the burst starts. It falls a much longer number of strobes after the burst ends.

When forward error correction is switched on, both edges move later by an extra number of strobes. That extra delay depends on the selected modulation. The FEC switch and the modulation select are adopted only while the block is idle. Idle means the output is low and no high sample is still travelling through the history. A burst already in flight therefore keeps the timing it started with.

Top module: `burst_enable_delay`

## Requirements
- R1: While `rst` is high at a clock edge, `en_out` is low after that edge. The sample history is also cleared, so a burst that starts after reset shows the normal timing.
- R2: `en_in` is sampled only at clock edges where `sym_stb` is high. `en_out` changes only after edges where `sym_stb` is high. Values of `en_in` in cycles without a strobe have no effect on `en_out`.
- R3: Let strobe n=0 be the first strobe at which `en_in` is sampled high after an idle stretch. Let X be the extra FEC delay. `en_out` goes high right after strobe n = 2 + X.
- R4: Let a burst hold `en_in` high for L strobes (n = 0 .. L-1) and sample it low at strobe n = L. `en_out` goes low right after strobe n = L + 13 + X.
- R5: X = 0 when `fec_on` is 0. When `fec_on` is 1, X depends on `mod_sel`: 2'b00 (BPSK) gives 8, 2'b01 (QPSK) gives 4, 2'b10 (16QAM) gives 2, and 2'b11 is treated as 16QAM (2).
- R6: `fec_on` and `mod_sel` take effect only while the block is idle. Idle means `en_out` is low and every sample in the history is low. A change made while a burst is in flight does not alter that burst's rise or fall timing.
- R7: A single-strobe burst (L = 1) still rises at n = 2 + X and falls at n = 14 + X. The output stays high across the gap between the two latencies. This requires successive bursts to be separated by at least 13 + X low strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | Single-cycle symbol strobe |
| en_in | input | 1 | Burst data-enable, sampled on strobe cycles |
| fec_on | input | 1 | Forward error correction active |
| mod_sel | input | 2 | Modulation: 00 BPSK, 01 QPSK, 10/11 16QAM |
| en_out | output | 1 | Delayed data-enable |

## Verification
The hardest case to reach from the ports is a configuration change that arrives while a burst is still draining. At that point the output is high, or low but with high samples still in the history. The bench changes `fec_on` and `mod_sel` one strobe after a burst starts. It then checks every following strobe against the timing of the configuration that was in place when the burst began. The bench also toggles `en_in` in the cycles between strobes. Finally, it applies reset in the middle of a burst and follows it with a fresh burst, to show that the history was emptied.

// File: rtl/burst_enable_delay.sv
module burst_enable_delay #(
  parameter int RISE_LAT  = 2,
  parameter int FALL_LAT  = 13,
  parameter int EXT_BPSK  = 8,
  parameter int EXT_QPSK  = 4,
  parameter int EXT_QAM16 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb,
  input  logic       en_in,
  input  logic       fec_on,
  input  logic [1:0] mod_sel,
  output logic       en_out
);

  localparam int MAX_EXT = (EXT_BPSK > EXT_QPSK) ? ((EXT_BPSK > EXT_QAM16) ? EXT_BPSK : EXT_QAM16)
                                                 : ((EXT_QPSK > EXT_QAM16) ? EXT_QPSK : EXT_QAM16);
  localparam int DEPTH   = FALL_LAT + MAX_EXT + 1;
  localparam int IW      = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] hist_q;
  logic             fec_act;
  logic [1:0]       mod_act;
  logic [IW-1:0]    ext;
  logic [IW-1:0]    rise_idx, fall_idx;
  logic             idle, rise_evt, fall_evt;

  always_comb begin
    ext = '0;
    if (fec_act) begin
      case (mod_act)
        2'b00:   ext = IW'(EXT_BPSK);
        2'b01:   ext = IW'(EXT_QPSK);
        default: ext = IW'(EXT_QAM16);
      endcase
    end
  end

  assign rise_idx = IW'(RISE_LAT - 1) + ext;
  assign fall_idx = IW'(FALL_LAT - 1) + ext;
  assign idle     = !en_out && (hist_q == '0);
  assign rise_evt = hist_q[rise_idx] && !hist_q[rise_idx + 1'b1];
  assign fall_evt = !hist_q[fall_idx] && hist_q[fall_idx + 1'b1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q  <= '0;
      en_out  <= 1'b0;
      fec_act <= 1'b0;
      mod_act <= 2'b00;
    end else begin
      if (idle) begin
        fec_act <= fec_on;
        mod_act <= mod_sel;
      end
      if (sym_stb) begin
        hist_q <= {hist_q[DEPTH-2:0], en_in};
        if (fall_evt)      en_out <= 1'b0;
        else if (rise_evt) en_out <= 1'b1;
      end
    end
  end

endmodule

module burst_enable_delay_chk #(
  parameter int W = 22
) (
  input logic         clk,
  input logic         rst,
  input logic         sym_stb,
  input logic         en_out,
  input logic         fec_act,
  input logic [1:0]   mod_act,
  input logic [W-1:0] hist_q
);

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst_seen_q) AST_RESET_LOW: assert (!en_out); // R1
  end

  AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
    !sym_stb |=> $stable(en_out)); // R2

  AST_RISE_HAS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $rose(en_out) |-> (hist_q != '0)); // R3

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    en_out |=> ($stable(fec_act) && $stable(mod_act))); // R6

endmodule

bind burst_enable_delay burst_enable_delay_chk #(.W(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .sym_stb(sym_stb), .en_out(en_out),
  .fec_act(fec_act), .mod_act(mod_act), .hist_q(hist_q)
);

// File: tb/tb_burst_enable_delay.sv
module tb_burst_enable_delay;
  logic clk = 1'b0, rst = 1'b1, sym_stb = 1'b0, en_in = 1'b0, fec_on = 1'b0;
  logic [1:0] mod_sel = 2'b00;
  logic en_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_enable_delay dut (.clk(clk), .rst(rst), .sym_stb(sym_stb), .en_in(en_in),
                          .fec_on(fec_on), .mod_sel(mod_sel), .en_out(en_out));

  function automatic int ext_of(input bit f, input logic [1:0] m);
    if (!f) return 0;
    case (m)
      2'b00: return 8;
      2'b01: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic check(input bit exp, input string req, input int n);
    checks++;
    if (en_out !== exp) begin
      fails++;
      $display("FAIL %s strobe %0d: en_out=%b expected %b", req, n, en_out, exp);
    end
  endtask

  // one strobe: en_in toggled in the non-strobe cycles to show they are ignored (R2)
  task automatic strobe(input bit e);
    @(negedge clk); en_in = e; sym_stb = 1'b1;
    @(negedge clk); sym_stb = 1'b0; en_in = ~e;
    @(negedge clk); en_in = e;
    @(negedge clk); en_in = ~e;
  endtask

  // burst of L strobes; if chg, config is altered at n=1 (R6)
  task automatic burst(input int len, input bit f, input logic [1:0] m, input bit chg);
    int x;
    bit exp;
    x = ext_of(f, m);
    @(negedge clk); fec_on = f; mod_sel = m;
    @(negedge clk);
    for (int n = 0; n <= len + 24; n++) begin
      if (chg && n == 1) begin fec_on = !f; mod_sel = m + 2'd1; end
      @(negedge clk); en_in = (n < len); sym_stb = 1'b1;
      @(negedge clk); sym_stb = 1'b0;
      exp = (n >= 2 + x) && (n < len + 13 + x);
      if (n == 2 + x) check(exp, "R3", n);
      else if (n == len + 13 + x) check(exp, "R4", n);
      else if (len == 1) check(exp, "R7", n);
      else if (chg) check(exp, "R6", n);
      else if (x != 0) check(exp, "R5", n);
      else check(exp, "R2", n);
      en_in = ~en_in;
      @(negedge clk); en_in = ~en_in;
    end
  endtask

  initial begin
    int lens[5] = '{1, 3, 11, 12, 20};
    repeat (3) @(negedge clk);
    check(1'b0, "R1", 0);
    rst = 1'b0;
    for (int f = 0; f < 2; f++)
      for (int m = 0; m < 4; m++)
        foreach (lens[i]) burst(lens[i], f[0], m[1:0], 1'b0);
    for (int m = 0; m < 4; m++) begin
      burst(5, 1'b1, m[1:0], 1'b1);
      burst(5, 1'b0, m[1:0], 1'b1);
    end
    // reset in mid-burst (R1)
    @(negedge clk); fec_on = 1'b0;
    for (int n = 0; n < 6; n++) strobe(1'b1);
    check(1'b1, "R1", 6);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(1'b0, "R1", 0);
    rst = 1'b0; en_in = 1'b0;
    burst(4, 1'b0, 2'b00, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule